// File: doc/BRIEF.md
# Active-Mask Lane Shadowing and Result Comparator

This block sits between register read and execute in one SIMT lane cluster. When a warp has diverged, the lanes masked off by the active mask would idle. The block turns them into shadow copies of active lanes. Each idle lane is paired with an active lane, and the active lane's register-read value is steered onto the idle lane's operand input. Both lanes then run the same operation on identical operands. The steering is purely combinational, so it adds no pipeline stage and only a multiplexer level of delay.

At write-back, the results of every active/shadow pair are compared. The mismatch vector, the coverage vector and a one-cycle error pulse are registered. Downstream flush and error handling use the pulse.

Pairing is fixed by the mask alone. Counting lanes from the highest index down, the k-th active lane is paired with the k-th inactive lane. Active lanes left over without an idle partner run unchecked. A full mask or an empty mask yields no pairs at all.

Top module: `lane_shadow_check`

## Requirements
- R1: Counting from the highest lane index downward, the k-th active lane (bit of `act_mask` = 1) is paired with the k-th inactive lane (bit = 0). The number of pairs is the smaller of the active count and the inactive count. `pair_vld` bit i is 1 exactly when lane i belongs to a pair.
- R2: A paired inactive lane receives on `op_out` the register-read value of its active partner. For example, with mask 4'b1100 the operands of lanes 3, 2, 1, 0 are the read values of lanes 3, 2, 3, 2.
- R3: Every active lane, and every inactive lane without a partner, receives its own register-read value on `op_out`.
- R4: `op_out`, `pair_idx` and `pair_vld` depend combinationally on `act_mask` and `rd_val`. A change is visible in the same cycle, with no clock edge in between.
- R5: `pair_idx` field i (bits i*IW upward) holds the lane index of lane i's partner. For an unpaired lane it holds i itself.
- R6: On the clock edge that samples `wb_valid`=1, `mism_vec` bit i is set exactly when lane i is an active lane paired under `wb_mask` and its `wb_res` differs from its partner's. No uncovered lane is ever set.
- R7: On the same edge, `cov_vec` bit i is set exactly when lane i is active under `wb_mask` and has a partner. An unpaired active lane is neither covered nor flagged, whatever its result.
- R8: `err_pulse` is 1 for exactly the one cycle after a write-back beat whose mismatch vector is non-zero. It is 0 after every other cycle.
- R9: A mask of all ones or all zeros produces no pairs, a zero coverage vector and no error.
- R10: While `rst_n` is low, and after its release, `err_pulse`, `mism_vec` and `cov_vec` are 0.
- R11: `mism_vec` and `cov_vec` keep their values in cycles where `wb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_mask | input | LANES | Active mask of the instruction at register read |
| rd_val | input | LANES*DW | Per-lane register-read values, lane i at bits i*DW upward |
| op_out | output | LANES*DW | Per-lane operands to the execute stage |
| pair_idx | output | LANES*IW | Partner lane index of each lane |
| pair_vld | output | LANES | Lane belongs to an active/shadow pair |
| wb_valid | input | 1 | Write-back results are presented this cycle |
| wb_mask | input | LANES | Active mask of the instruction at write-back |
| wb_res | input | LANES*DW | Per-lane execution results |
| err_pulse | output | 1 | One-cycle error indication |
| mism_vec | output | LANES | Active lanes whose result disagreed with their shadow |
| cov_vec | output | LANES | Active lanes whose result was verified |

## Verification
The hardest cases to reach from the ports are results that differ only on lanes the comparator must ignore. These are an unpaired active lane, a spare inactive lane, and a pair whose two members are both corrupted in the same way. A correct execution unit never produces them. The bench therefore models the execution units itself and applies a per-lane fault pattern to the results, and each scenario chooses which lanes to corrupt. A sweep over every 4-lane mask combines this with expected pairings. The bench builds these by listing active and inactive lanes from the top and zipping the two lists, a method separate from the rank counting used in the RTL.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // Role of one lane under a given active mask
  typedef enum logic [1:0] {
    ROLE_SPARE   = 2'd0,  // inactive, no partner
    ROLE_LONE    = 2'd1,  // active, no partner (unchecked)
    ROLE_PRIMARY = 2'd2,  // active, shadowed by an inactive lane
    ROLE_SHADOW  = 2'd3   // inactive, duplicates an active lane
  } lane_role_e;
endpackage

// File: rtl/lsc_pair_map.sv
module lsc_pair_map #(
  parameter int LANES = 4,
  parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]   mask,
  output logic [IW-1:0]      partner [LANES],
  output logic [LANES-1:0]   paired,
  output lsc_pkg::lane_role_e role [LANES]
);
  import lsc_pkg::*;

  localparam int CW = $clog2(LANES + 1);

  // Number of lanes above 'lane' whose mask bit equals 'want'
  function automatic logic [CW-1:0] count_above(input logic [LANES-1:0] m,
                                                input int lane, input logic want);
    logic [CW-1:0] c;
    c = '0;
    for (int j = LANES - 1; j > lane; j--)
      if (m[j] == want) c = c + CW'(1);
    return c;
  endfunction

  // Lane holding rank r (from the top) among lanes with mask bit 'want'.
  // MSB of the result flags that such a lane exists.
  function automatic logic [IW:0] lane_of_rank(input logic [LANES-1:0] m,
                                               input logic want, input logic [CW-1:0] r);
    logic [IW:0]   hit;
    logic [CW-1:0] seen;
    hit  = '0;
    seen = '0;
    for (int j = LANES - 1; j >= 0; j--) begin
      if (m[j] == want) begin
        if (seen == r && !hit[IW]) hit = {1'b1, IW'(j)};
        seen = seen + CW'(1);
      end
    end
    return hit;
  endfunction

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [IW:0] hit;
      hit        = lane_of_rank(mask, !mask[i], count_above(mask, i, mask[i]));
      paired[i]  = hit[IW];
      partner[i] = hit[IW] ? hit[IW-1:0] : IW'(i);
      if (!hit[IW]) role[i] = mask[i] ? ROLE_LONE : ROLE_SPARE;
      else          role[i] = mask[i] ? ROLE_PRIMARY : ROLE_SHADOW;
    end
  end
endmodule

// File: rtl/lsc_operand_fwd.sv
module lsc_operand_fwd #(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DW-1:0]       rd      [LANES],
  input  logic [IW-1:0]       partner [LANES],
  input  lsc_pkg::lane_role_e role    [LANES],
  output logic [DW-1:0]       op      [LANES]
);
  import lsc_pkg::*;

  // One mux level per lane: shadows take the partner's read value
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign op[g] = (role[g] == ROLE_SHADOW) ? rd[partner[g]] : rd[g];
  end
endmodule

// File: rtl/lsc_result_cmp.sv
module lsc_result_cmp #(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_valid,
  input  logic [LANES-1:0] wb_mask,
  input  logic [DW-1:0]    res [LANES],
  output logic             err_pulse,
  output logic [LANES-1:0] mism_vec,
  output logic [LANES-1:0] cov_vec
);
  import lsc_pkg::*;

  logic [IW-1:0]  wb_partner [LANES];
  logic [LANES-1:0] wb_paired;
  lane_role_e     wb_role    [LANES];
  logic [LANES-1:0] mism_c;
  logic [LANES-1:0] cov_c;
  logic             any_mism;

  // Pairing recomputed from the write-back mask
  lsc_pair_map #(.LANES(LANES), .IW(IW)) i_wb_map (
    .mask    (wb_mask),
    .partner (wb_partner),
    .paired  (wb_paired),
    .role    (wb_role)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign mism_c[g] = (wb_role[g] == ROLE_PRIMARY) && (res[g] != res[wb_partner[g]]);
    assign cov_c[g]  = wb_paired[g] && wb_mask[g];
  end

  assign any_mism = |mism_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      mism_vec  <= '0;
      cov_vec   <= '0;
    end else begin
      err_pulse <= wb_valid && any_mism;
      if (wb_valid) begin
        mism_vec <= mism_c;
        cov_vec  <= cov_c;
      end
    end
  end

  AST_ERR_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |=> !err_pulse);  // R8
  AST_ERR_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (mism_vec != '0));  // R8
  AST_MISM_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (mism_vec & ~cov_vec) == '0);  // R6
  AST_DEGENERATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && (wb_mask == '0 || &wb_mask)) |=> (!err_pulse && cov_vec == '0));  // R9
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |=> ($stable(mism_vec) && $stable(cov_vec)));  // R11
endmodule

// File: rtl/lane_shadow_check.sv
module lane_shadow_check #(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    act_mask,
  input  logic [LANES*DW-1:0] rd_val,
  output logic [LANES*DW-1:0] op_out,
  output logic [LANES*IW-1:0] pair_idx,
  output logic [LANES-1:0]    pair_vld,
  input  logic                wb_valid,
  input  logic [LANES-1:0]    wb_mask,
  input  logic [LANES*DW-1:0] wb_res,
  output logic                err_pulse,
  output logic [LANES-1:0]    mism_vec,
  output logic [LANES-1:0]    cov_vec
);
  import lsc_pkg::*;

  logic [DW-1:0]  rd_a   [LANES];
  logic [DW-1:0]  op_a   [LANES];
  logic [DW-1:0]  res_a  [LANES];
  logic [IW-1:0]  part_a [LANES];
  lane_role_e     role_a [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign rd_a[g]                = rd_val[g*DW +: DW];
    assign res_a[g]               = wb_res[g*DW +: DW];
    assign op_out[g*DW +: DW]     = op_a[g];
    assign pair_idx[g*IW +: IW]   = part_a[g];
  end

  lsc_pair_map #(.LANES(LANES), .IW(IW)) i_rd_map (
    .mask    (act_mask),
    .partner (part_a),
    .paired  (pair_vld),
    .role    (role_a)
  );

  lsc_operand_fwd #(.LANES(LANES), .DW(DW), .IW(IW)) i_fwd (
    .rd      (rd_a),
    .partner (part_a),
    .role    (role_a),
    .op      (op_a)
  );

  lsc_result_cmp #(.LANES(LANES), .DW(DW), .IW(IW)) i_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_valid  (wb_valid),
    .wb_mask   (wb_mask),
    .res       (res_a),
    .err_pulse (err_pulse),
    .mism_vec  (mism_vec),
    .cov_vec   (cov_vec)
  );

  AST_PAIR_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pair_vld & act_mask) == $countones(pair_vld & ~act_mask));  // R1
  AST_DEGENERATE_NOPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mask == '0 || &act_mask) |-> (pair_vld == '0));  // R9

  for (genvar g = 0; g < LANES; g++) begin : g_ast
    AST_SHADOW_SAME_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_vld[g] && !act_mask[g]) |-> (op_a[g] == op_a[part_a[g]]));  // R2
    AST_ACTIVE_OWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
      act_mask[g] |-> (op_a[g] == rd_a[g]));  // R3
  end
endmodule

// File: tb/test_lane_shadow_check.sv
`timescale 1ns/1ps
module test_lane_shadow_check;
  localparam int LANES = 4;
  localparam int DW    = 32;
  localparam int IW    = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [LANES-1:0]    act_mask = '0;
  logic [LANES*DW-1:0] rd_val = '0;
  logic [LANES*DW-1:0] op_out;
  logic [LANES*IW-1:0] pair_idx;
  logic [LANES-1:0]    pair_vld;
  logic                wb_valid = 1'b0;
  logic [LANES-1:0]    wb_mask = '0;
  logic [LANES*DW-1:0] wb_res = '0;
  logic                err_pulse;
  logic [LANES-1:0]    mism_vec;
  logic [LANES-1:0]    cov_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int exp_p [LANES];
  bit exp_v [LANES];

  always #4 clk = ~clk;  // 125 MHz

  lane_shadow_check #(.LANES(LANES), .DW(DW), .IW(IW)) i_lane_shadow_check (
    .clk, .rst_n, .act_mask, .rd_val, .op_out, .pair_idx, .pair_vld,
    .wb_valid, .wb_mask, .wb_res, .err_pulse, .mism_vec, .cov_vec
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Build expected pairing by zipping the top-down active and inactive lists
  task automatic build_pairs(input logic [LANES-1:0] m);
    int al [LANES];
    int il [LANES];
    int na = 0;
    int ni = 0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (m[l]) begin al[na] = l; na++; end
      else      begin il[ni] = l; ni++; end
    end
    for (int l = 0; l < LANES; l++) begin exp_p[l] = l; exp_v[l] = 0; end
    for (int k = 0; k < na && k < ni; k++) begin
      exp_p[al[k]] = il[k]; exp_v[al[k]] = 1;
      exp_p[il[k]] = al[k]; exp_v[il[k]] = 1;
    end
  endtask

  function automatic logic [DW-1:0] rd_of(input int seed, input int l);
    return 32'hA000_0000 + DW'(seed * 256) + DW'(l * 17);
  endfunction

  // Drive mask and read values, then check forwarding and pairing
  task automatic apply_read(input logic [LANES-1:0] m, input int seed);
    @(negedge clk);
    act_mask = m;
    for (int l = 0; l < LANES; l++) rd_val[l*DW +: DW] = rd_of(seed, l);
    #1;
    build_pairs(m);
    for (int l = 0; l < LANES; l++) begin
      int src;
      src = (exp_v[l] && !m[l]) ? exp_p[l] : l;
      chk($sformatf("R2/R3 op m=%b lane%0d", m, l), op_out[l*DW +: DW], rd_of(seed, src));
      chk($sformatf("R5 idx m=%b lane%0d", m, l), pair_idx[l*IW +: IW], exp_p[l]);
      chk($sformatf("R1 vld m=%b lane%0d", m, l), pair_vld[l], exp_v[l]);
    end
  endtask

  // Behavioural ALU with a per-lane fault pattern, then write-back checks
  task automatic writeback(input logic [LANES-1:0] m, input logic [LANES-1:0] fault,
                           input string tag);
    logic [LANES-1:0] em;
    logic [LANES-1:0] ec;
    em = '0; ec = '0;
    build_pairs(m);
    for (int l = 0; l < LANES; l++) begin
      wb_res[l*DW +: DW] = op_out[l*DW +: DW] * 3 + 7 + (fault[l] ? 32'h0000_0100 : 32'h0);
      if (m[l] && exp_v[l]) begin
        ec[l] = 1'b1;
        em[l] = fault[l] ^ fault[exp_p[l]];
      end
    end
    wb_mask  = m;
    wb_valid = 1'b1;
    @(negedge clk);
    wb_valid = 1'b0;
    chk({tag, " R8 err"}, err_pulse, |em);
    chk({tag, " R6 mism"}, mism_vec, em);
    chk({tag, " R7 cov"}, cov_vec, ec);
    wb_res = '0;
    @(negedge clk);
    chk({tag, " R8 err drops"}, err_pulse, 1'b0);
    chk({tag, " R11 mism held"}, mism_vec, em);
    chk({tag, " R11 cov held"}, cov_vec, ec);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 err in reset", err_pulse, 1'b0);
    chk("R10 mism in reset", mism_vec, '0);
    chk("R10 cov in reset", cov_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 err after reset", err_pulse, 1'b0);
    chk("R10 cov after reset", cov_vec, '0);
  endtask

  task automatic t_example_1100;
    apply_read(4'b1100, 5);
    chk("R2 lane1 gets lane3", op_out[1*DW +: DW], rd_of(5, 3));
    chk("R2 lane0 gets lane2", op_out[0*DW +: DW], rd_of(5, 2));
    writeback(4'b1100, 4'b0000, "ex1100 clean");
    apply_read(4'b1100, 6);
    writeback(4'b1100, 4'b0001, "ex1100 shadow fault");
  endtask

  task automatic t_comb_path;
    apply_read(4'b1000, 9);
    #1;
    rd_val[3*DW +: DW] = 32'h1234_5678;
    #1;
    chk("R4 shadow follows read same cycle", op_out[2*DW +: DW], 32'h1234_5678);
    act_mask = 4'b0100;
    #1;
    chk("R4 mask change same cycle", pair_idx[3*IW +: IW], 2);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < (1 << LANES); m++) begin
      logic [LANES-1:0] f;
      apply_read(LANES'(m), m + 20);
      writeback(LANES'(m), '0, $sformatf("sweep m=%0h clean", m));
      // corrupt the partner of the highest active lane, if it has one
      f = '0;
      build_pairs(LANES'(m));
      for (int l = LANES - 1; l >= 0; l--)
        if (m[l] && exp_v[l] && f == '0) f[exp_p[l]] = 1'b1;
      apply_read(LANES'(m), m + 40);
      writeback(LANES'(m), f, $sformatf("sweep m=%0h fault", m));
    end
  endtask

  task automatic t_ignored;
    // lanes 2 and 1 active without partner: their faults must go unseen
    apply_read(4'b1110, 60);
    writeback(4'b1110, 4'b0110, "R7 lone lanes");
    // fault on both members of a pair: results agree, no error
    apply_read(4'b1010, 61);
    writeback(4'b1010, 4'b1100, "R6 twin fault");
    // spare inactive lane corrupted, no effect
    apply_read(4'b0001, 62);
    writeback(4'b0001, 4'b0100, "R6 spare lane");
  endtask

  task automatic t_degenerate;
    apply_read(4'b1111, 70);
    chk("R9 full mask no pairs", pair_vld, '0);
    writeback(4'b1111, 4'b0101, "R9 full");
    apply_read(4'b0000, 71);
    chk("R9 empty mask no pairs", pair_vld, '0);
    writeback(4'b0000, 4'b1001, "R9 empty");
  endtask

  initial begin
    t_reset();
    t_example_1100();
    t_comb_path();
    t_sweep();
    t_ignored();
    t_degenerate();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule